// File: doc/BRIEF.md
# Masked Wakeup Frame Matcher

The matcher watches a received byte stream and decides, for each of several stored wakeup templates, whether the frame just received is one of the patterns that should wake the host. Each template slot holds a 64-bit byte mask, an expected CRC byte and an auxiliary byte. For each slot, a CRC is run only over the received bytes whose mask bit is set, and the last masked byte is kept. When the frame ends, the result is compared with the stored values. The stored CRCs are computed by host software with the same algorithm.

In normal mode, each mask bit selects one received byte at offsets 12 to 75. An 8-bit CRC (polynomial x^8+x^2+x+1, start value 0xFF, bits of each byte fed least significant first) must equal the slot's CRC byte, and the last masked byte must equal the slot's auxiliary byte. When long mode is enabled, each slot pair starting at slot 2 ((2,3), (4,5), (6,7)) merges into one long template. The long template's mask covers offsets 0 to 127 (lead slot mask = offsets 0..63, tail slot mask = offsets 64..127). It uses a 16-bit CRC (polynomial 0x1021, start value 0xFFFF, bits fed least significant first). The low CRC byte is held in the lead slot's CRC byte and the high byte in the lead slot's auxiliary byte, so the last-byte check is dropped. The result is reported on the lead slot. A hit is only reported when the frame is free of CRC errors, its destination address matched and wake reporting is enabled.

Top module: `wakeup_frame_matcher`

## Requirements
- R1: While and right after reset, `wake_hit_vec` and `wake_any` are 0.
- R2: In normal mode, slot s reports a hit when the 8-bit CRC over the masked bytes at offsets 12..75 (mask bit i selects offset 12+i) equals `tmpl_crc[s]` and the last masked byte equals `tmpl_aux[s]`.
- R3: In normal mode, a frame whose masked-byte CRC matches but whose last masked byte differs from `tmpl_aux[s]` gives no hit on slot s.
- R4: In normal mode, bytes at offsets below 12 or above 75 have no effect on a slot's result.
- R5: With `long_en`=1, lead slot 2k (k>=1) matches when the 16-bit CRC over offsets 0..127 selected by {mask[2k+1],mask[2k]} equals {`tmpl_aux[2k]`,`tmpl_crc[2k]`}.
- R6: With `long_en`=1, the tail slots 3, 5 and 7 never report a hit, whatever their CRC and auxiliary bytes hold.
- R7: A hit needs `rx_crc_ok`, `rx_da_ok` and `pme_en` all 1 in the cycle of `rx_eof`. If any of them is 0, the result vector is all zero.
- R8: The result appears one cycle after the `rx_eof` strobe, lasts exactly one cycle, and `wake_any` is the OR of the slot hits.
- R9: A frame that ends before the end of the mask window is evaluated over the masked bytes that arrived.
- R10: Slots 0 and 1 keep normal-mode behaviour while `long_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte present on `rx_data` |
| rx_sof | input | 1 | Marks the first byte of a frame (offset 0), with `rx_valid` |
| rx_data | input | 8 | Received byte |
| rx_eof | input | 1 | One-cycle end-of-frame strobe, after the last byte |
| rx_crc_ok | input | 1 | Frame check sequence was good (sampled with `rx_eof`) |
| rx_da_ok | input | 1 | Destination address matched (sampled with `rx_eof`) |
| pme_en | input | 1 | Wake reporting enable |
| long_en | input | 1 | Merge slot pairs from slot 2 upward into long templates |
| tmpl_mask | input | NUM_SLOTS*64 | Per-slot byte masks, slot s in bits [64s+63:64s] |
| tmpl_crc | input | NUM_SLOTS*8 | Per-slot stored CRC byte (low CRC byte in long mode) |
| tmpl_aux | input | NUM_SLOTS*8 | Per-slot last masked byte, or high CRC byte for a long lead |
| wake_hit_vec | output | NUM_SLOTS | Per-slot match pulse |
| wake_any | output | 1 | Any slot matched |

## Verification
A corrupted per-slot accumulator or last-byte register shows as a false hit or a missing hit on that slot's bit. This is visible exactly one cycle after the end-of-frame strobe and not before, because nothing is reported mid-frame. A wrong offset count shifts the mask window, which shows up as mismatches on frames whose only difference lies just inside or just outside the window edges. A slip in mode selection shows as hits on tail slots or as missed long templates in the first frame after the mode is set.

// File: rtl/wf_pkg.sv
package wf_pkg;
  localparam logic [7:0]  POLY8  = 8'h07;
  localparam logic [15:0] POLY16 = 16'h1021;
  localparam logic [7:0]  SEED8  = 8'hFF;
  localparam logic [15:0] SEED16 = 16'hFFFF;

  // one byte into the 8-bit accumulator, least significant data bit first
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[7] ^ d[i];
      r  = {r[6:0], 1'b0};
      if (fb) r = r ^ POLY8;
    end
    return r;
  endfunction

  // one byte into the 16-bit accumulator, least significant data bit first
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ POLY16;
    end
    return r;
  endfunction
endpackage

// File: rtl/wf_byte_offset.sv
module wf_byte_offset #(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic             rx_sof,
  output logic [OFS_W-1:0] cur_ofs
);
  localparam logic [OFS_W-1:0] OFS_MAX = '1;
  logic [OFS_W-1:0] cnt_q;

  assign cur_ofs = rx_sof ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (rx_valid) begin
      if (cur_ofs != OFS_MAX) cnt_q <= cur_ofs + 1'b1;
      else                    cnt_q <= OFS_MAX;
    end
  end
endmodule

// File: rtl/wf_slot_engine.sv
module wf_slot_engine
  import wf_pkg::*;
#(
  parameter int OFS_W      = 8,
  parameter int NORM_START = 12,
  parameter int NORM_BYTES = 64,
  parameter int LONG_BYTES = 128
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  byte_en,
  input  logic                  sof,
  input  logic [7:0]            data,
  input  logic [OFS_W-1:0]      ofs,
  input  logic                  long_mode,
  input  logic                  slot_off,
  input  logic [NORM_BYTES-1:0] mask_lo,
  input  logic [NORM_BYTES-1:0] mask_hi,
  input  logic [7:0]            exp_crc,
  input  logic [7:0]            exp_aux,
  output logic                  tmpl_ok
);
  localparam int NIDX_W = $clog2(NORM_BYTES);
  localparam int LIDX_W = $clog2(LONG_BYTES);
  localparam logic [OFS_W-1:0] N_LO = OFS_W'(NORM_START);
  localparam logic [OFS_W-1:0] N_HI = OFS_W'(NORM_START + NORM_BYTES);
  localparam logic [OFS_W-1:0] L_HI = OFS_W'(LONG_BYTES);

  logic [LONG_BYTES-1:0] mask_long;
  logic [NIDX_W-1:0]     n_idx;
  logic [LIDX_W-1:0]     l_idx;
  logic                  sel;
  logic [15:0]           acc_q, base, stepped;
  logic [7:0]            last_q;

  assign mask_long = {mask_hi, mask_lo};
  assign n_idx     = NIDX_W'(ofs - N_LO);
  assign l_idx     = LIDX_W'(ofs);

  always_comb begin
    if (long_mode) sel = (ofs < L_HI) && mask_long[l_idx];
    else           sel = (ofs >= N_LO) && (ofs < N_HI) && mask_lo[n_idx];
  end

  always_comb begin
    if (sof) base = long_mode ? SEED16 : {8'h00, SEED8};
    else     base = acc_q;
    if (long_mode) stepped = crc16_step(base, data);
    else           stepped = {8'h00, crc8_step(base[7:0], data)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= SEED16;
      last_q <= '0;
    end else if (byte_en) begin
      acc_q <= sel ? stepped : base;
      if (sel)      last_q <= data;
      else if (sof) last_q <= '0;
    end
  end

  always_comb begin
    if (slot_off)       tmpl_ok = 1'b0;
    else if (long_mode) tmpl_ok = (acc_q == {exp_aux, exp_crc});
    else                tmpl_ok = (acc_q[7:0] == exp_crc) && (last_q == exp_aux);
  end
endmodule

// File: rtl/wf_result_reg.sv
module wf_result_reg #(
  parameter int NUM_SLOTS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_eof,
  input  logic                 rx_crc_ok,
  input  logic                 rx_da_ok,
  input  logic                 pme_en,
  input  logic [NUM_SLOTS-1:0] ok_vec,
  output logic [NUM_SLOTS-1:0] hit_vec,
  output logic                 hit_any
);
  logic gate;
  assign gate = rx_eof && rx_crc_ok && rx_da_ok && pme_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_vec <= '0;
      hit_any <= 1'b0;
    end else begin
      hit_vec <= gate ? ok_vec : '0;
      hit_any <= gate && (|ok_vec);
    end
  end
endmodule

// File: rtl/wakeup_frame_matcher.sv
module wakeup_frame_matcher #(
  parameter int NUM_SLOTS  = 8,
  parameter int LONG_BASE  = 2,
  parameter int NORM_START = 12,
  parameter int NORM_BYTES = 64,
  parameter int LONG_BYTES = 128
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            rx_valid,
  input  logic                            rx_sof,
  input  logic [7:0]                      rx_data,
  input  logic                            rx_eof,
  input  logic                            rx_crc_ok,
  input  logic                            rx_da_ok,
  input  logic                            pme_en,
  input  logic                            long_en,
  input  logic [NUM_SLOTS*NORM_BYTES-1:0] tmpl_mask,
  input  logic [NUM_SLOTS*8-1:0]          tmpl_crc,
  input  logic [NUM_SLOTS*8-1:0]          tmpl_aux,
  output logic [NUM_SLOTS-1:0]            wake_hit_vec,
  output logic                            wake_any
);
  localparam int OFS_W = $clog2(LONG_BYTES) + 1;

  logic [OFS_W-1:0]     cur_ofs;
  logic [NUM_SLOTS-1:0] ok_vec;

  wf_byte_offset #(.OFS_W(OFS_W)) u_ofs (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .cur_ofs(cur_ofs)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam bit IS_LEAD = (s >= LONG_BASE) && (((s - LONG_BASE) % 2) == 0)
                             && (s + 1 < NUM_SLOTS);
    localparam bit IS_TAIL = (s > LONG_BASE) && (((s - LONG_BASE) % 2) == 1);
    logic [NORM_BYTES-1:0] hi_mask;

    if (IS_LEAD) begin : g_lead
      assign hi_mask = tmpl_mask[(s+1)*NORM_BYTES +: NORM_BYTES];
    end else begin : g_solo
      assign hi_mask = '0;
    end

    wf_slot_engine #(
      .OFS_W(OFS_W), .NORM_START(NORM_START),
      .NORM_BYTES(NORM_BYTES), .LONG_BYTES(LONG_BYTES)
    ) u_eng (
      .clk       (clk),
      .rst       (rst),
      .byte_en   (rx_valid),
      .sof       (rx_sof),
      .data      (rx_data),
      .ofs       (cur_ofs),
      .long_mode (long_en && IS_LEAD),
      .slot_off  (long_en && IS_TAIL),
      .mask_lo   (tmpl_mask[s*NORM_BYTES +: NORM_BYTES]),
      .mask_hi   (hi_mask),
      .exp_crc   (tmpl_crc[s*8 +: 8]),
      .exp_aux   (tmpl_aux[s*8 +: 8]),
      .tmpl_ok   (ok_vec[s])
    );
  end

  wf_result_reg #(.NUM_SLOTS(NUM_SLOTS)) u_res (
    .clk(clk), .rst(rst), .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok),
    .rx_da_ok(rx_da_ok), .pme_en(pme_en), .ok_vec(ok_vec),
    .hit_vec(wake_hit_vec), .hit_any(wake_any)
  );
endmodule

// File: rtl/wf_match_checker.sv
module wf_match_checker #(
  parameter int NUM_SLOTS = 8,
  parameter int LONG_BASE = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rx_eof,
  input logic                 rx_crc_ok,
  input logic                 rx_da_ok,
  input logic                 pme_en,
  input logic                 long_en,
  input logic [NUM_SLOTS-1:0] wake_hit_vec,
  input logic                 wake_any
);
  function automatic logic [NUM_SLOTS-1:0] tail_bits();
    logic [NUM_SLOTS-1:0] t;
    t = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if ((s > LONG_BASE) && (((s - LONG_BASE) % 2) == 1)) t[s] = 1'b1;
    return t;
  endfunction
  localparam logic [NUM_SLOTS-1:0] TAIL_MASK = tail_bits();

  // R1
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (wake_hit_vec == '0 && !wake_any));

  // R8
  a_r8_hit_needs_eof: assert property (@(posedge clk) disable iff (rst)
    (wake_hit_vec != '0) |-> $past(rx_eof));

  // R8
  a_r8_single_cycle: assert property (@(posedge clk) disable iff (rst)
    (wake_any && !rx_eof) |=> !wake_any);

  // R7
  a_r7_gated: assert property (@(posedge clk) disable iff (rst)
    wake_any |-> $past(rx_crc_ok && rx_da_ok && pme_en));

  // R6
  a_r6_tail_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(long_en) |-> ((wake_hit_vec & TAIL_MASK) == '0));
endmodule

bind wakeup_frame_matcher wf_match_checker #(
  .NUM_SLOTS(NUM_SLOTS), .LONG_BASE(LONG_BASE)
) u_chk (
  .clk(clk), .rst(rst), .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok),
  .rx_da_ok(rx_da_ok), .pme_en(pme_en), .long_en(long_en),
  .wake_hit_vec(wake_hit_vec), .wake_any(wake_any)
);

// File: tb/wakeup_frame_matcher_test.sv
`timescale 1ns/1ps
module wakeup_frame_matcher_test;
  localparam int NS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_crc_ok = 0, rx_da_ok = 0;
  logic pme_en = 0, long_en = 0;
  logic [7:0] rx_data = '0;
  logic [NS*64-1:0] tmpl_mask;
  logic [NS*8-1:0]  tmpl_crc, tmpl_aux;
  logic [NS-1:0]    wake_hit_vec;
  logic             wake_any;

  logic [63:0] t_mask [NS];
  logic [7:0]  t_crc  [NS];
  logic [7:0]  t_aux  [NS];
  logic [7:0]  fr     [160];

  int checks = 0, fails = 0;
  logic [NS-1:0] got, got_after;
  logic got_any;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      tmpl_mask[s*64 +: 64] = t_mask[s];
      tmpl_crc[s*8 +: 8]    = t_crc[s];
      tmpl_aux[s*8 +: 8]    = t_aux[s];
    end
  end

  wakeup_frame_matcher uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
    .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok), .rx_da_ok(rx_da_ok), .pme_en(pme_en),
    .long_en(long_en), .tmpl_mask(tmpl_mask), .tmpl_crc(tmpl_crc), .tmpl_aux(tmpl_aux),
    .wake_hit_vec(wake_hit_vec), .wake_any(wake_any)
  );

  // independent bit-serial reference CRCs
  function automatic logic [7:0] ref_c8(logic [7:0] c, logic [7:0] d);
    for (int b = 0; b < 8; b++)
      c = (c[7] != d[b]) ? ((c << 1) ^ 8'h07) : (c << 1);
    return c;
  endfunction
  function automatic logic [15:0] ref_c16(logic [15:0] c, logic [7:0] d);
    for (int b = 0; b < 8; b++)
      c = (c[15] != d[b]) ? ((c << 1) ^ 16'h1021) : (c << 1);
    return c;
  endfunction

  function automatic bool_sel(int s, bit lng, int i);
    logic [127:0] m;
    if (lng) begin
      m = {t_mask[s+1], t_mask[s]};
      return (i < 128) ? m[i] : 1'b0;
    end
    return (i >= 12 && i < 76) ? t_mask[s][i-12] : 1'b0;
  endfunction

  task automatic signature(int s, bit lng, int n, output logic [15:0] c16,
                           output logic [7:0] c8, output logic [7:0] lb);
    c16 = 16'hFFFF; c8 = 8'hFF; lb = 8'h00;
    for (int i = 0; i < n; i++) begin
      if (bool_sel(s, lng, i)) begin
        if (lng) c16 = ref_c16(c16, fr[i]);
        else     c8  = ref_c8(c8, fr[i]);
        lb = fr[i];
      end
    end
  endtask

  function automatic bit is_lead(int s); return long_en && s >= 2 && s % 2 == 0; endfunction
  function automatic bit is_tail(int s); return long_en && s >= 3 && s % 2 == 1; endfunction

  task automatic program_slot(int s, int n);
    logic [15:0] c16; logic [7:0] c8, lb;
    signature(s, is_lead(s), n, c16, c8, lb);
    if (is_lead(s)) begin t_crc[s] = c16[7:0]; t_aux[s] = c16[15:8]; end
    else            begin t_crc[s] = c8;       t_aux[s] = lb;        end
  endtask

  task automatic model(int n, bit gate, output logic [NS-1:0] e);
    logic [15:0] c16; logic [7:0] c8, lb;
    e = '0;
    for (int s = 0; s < NS; s++) begin
      signature(s, is_lead(s), n, c16, c8, lb);
      if (is_tail(s))      e[s] = 1'b0;
      else if (is_lead(s)) e[s] = (c16 == {t_aux[s], t_crc[s]});
      else                 e[s] = (c8 == t_crc[s]) && (lb == t_aux[s]);
    end
    if (!gate) e = '0;
  endtask

  task automatic fill(int seed, int n);
    int v = seed;
    for (int i = 0; i < n; i++) begin
      v = v * 1103515245 + 12345;
      fr[i] = v[23:16];
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(int n, bit crcok, bit daok);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (i == 0); rx_data = fr[i];
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 1; rx_crc_ok = crcok; rx_da_ok = daok;
    @(negedge clk);
    rx_eof = 0; rx_crc_ok = 0; rx_da_ok = 0;
    got = wake_hit_vec; got_any = wake_any;
    @(negedge clk);
    got_after = wake_hit_vec;
    @(negedge clk);
  endtask

  task automatic run_and_check(string tag, int n, bit crcok, bit daok);
    logic [NS-1:0] e;
    model(n, crcok && daok && pme_en, e);
    send(n, crcok, daok);
    chk(tag, 32'(got), 32'(e));
    chk({tag, " R8 any"}, 32'(got_any), 32'(|e));
    chk({tag, " R8 one-cycle"}, 32'(got_after), 32'h0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 reset hits", 32'(wake_hit_vec), 32'h0);
    chk("R1 reset any", 32'(wake_any), 32'h0);
  endtask

  task automatic t_normal;
    fill(7, 100);
    t_mask[0] = 64'h8000_0F00_00F0_0013;
    t_mask[1] = 64'h0000_0000_FFFF_FFFF;
    program_slot(0, 100); program_slot(1, 100);
    run_and_check("R2 normal match", 100, 1, 1);
    chk("R2 slot0 hit", 32'(got[0]), 32'h1);
    chk("R2 slot1 hit", 32'(got[1]), 32'h1);
  endtask

  task automatic t_last_byte;
    t_aux[0] = t_aux[0] ^ 8'h01;
    run_and_check("R3 last byte differs", 100, 1, 1);
    chk("R3 slot0 no hit", 32'(got[0]), 32'h0);
    t_aux[0] = t_aux[0] ^ 8'h01;
  endtask

  task automatic t_window;
    fr[3] = ~fr[3]; fr[11] = ~fr[11]; fr[76] = ~fr[76]; fr[90] = ~fr[90];
    run_and_check("R4 outside window", 100, 1, 1);
    chk("R4 slot0 still hits", 32'(got[0]), 32'h1);
  endtask

  task automatic t_gating;
    run_and_check("R7 crc bad", 100, 0, 1);
    run_and_check("R7 addr bad", 100, 1, 0);
    pme_en = 0;
    run_and_check("R7 pme off", 100, 1, 1);
    chk("R7 pme off none", 32'(got), 32'h0);
    pme_en = 1;
  endtask

  task automatic t_short;
    fill(99, 40);
    t_mask[1] = 64'hFFFF_FFFF_0000_F00F;
    program_slot(1, 40);
    run_and_check("R9 short frame", 40, 1, 1);
    chk("R9 slot1 hit", 32'(got[1]), 32'h1);
  endtask

  task automatic t_long;
    long_en = 1;
    fill(21, 130);
    t_mask[0] = 64'h0000_0001_0000_1001;
    t_mask[2] = 64'h0000_0000_0000_000F;
    t_mask[3] = 64'h8000_0000_0000_0100;
    t_mask[4] = 64'hFFFF_0000_0000_0000;
    t_mask[5] = 64'h0;
    program_slot(0, 130); program_slot(2, 130); program_slot(4, 130);
    t_crc[3] = 8'hA5; t_aux[3] = 8'h5A; t_crc[5] = 8'hFF; t_aux[5] = 8'h00;
    run_and_check("R5 long match", 130, 1, 1);
    chk("R5 slot2 hit", 32'(got[2]), 32'h1);
    chk("R5 slot4 hit", 32'(got[4]), 32'h1);
    chk("R6 tails silent", 32'({got[7], got[5], got[3]}), 32'h0);
    chk("R10 slot0 normal in long", 32'(got[0]), 32'h1);
    fr[2] = fr[2] ^ 8'h40;
    run_and_check("R5 early byte changes long", 130, 1, 1);
    chk("R5 slot2 miss", 32'(got[2]), 32'h0);
    long_en = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin t_mask[s] = '0; t_crc[s] = '0; t_aux[s] = '0; end
    repeat (4) @(negedge clk);
    t_reset();
    rst = 0;
    pme_en = 1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_last_byte();
    t_window();
    t_gating();
    t_short();
    t_long();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule